// File: doc/BRIEF.md
# Partitioned Spectrum Multiply-Accumulate Core

This block is the frequency-domain heart of a uniformly partitioned overlap-save convolver. Upstream logic streams in one complex input spectrum per block, one bin per handshake, and this core keeps the most recent `P` spectra in a circular history. Each bin is multiplied against the filter spectra of all `P` impulse-response partitions and summed. The newest spectrum is paired with partition 0 and the oldest with partition `P-1`. Each resulting output bin is streamed out to an inverse transform stage.

The signals are real, so a spectrum is carried as bins 0 to `K` only (`K+1` bins for a `2K`-point transform). Bins above a programmable cutoff index are neither fetched nor multiplied, and their output is zero. The filter spectra are loaded through a simple write port before streaming starts. Products are accumulated at full precision. The sum is then shifted right by `OSHIFT` and saturated to the output width.

Top module: `fdl_accum`

## Requirements
- R1: While reset is asserted and on the first edge after it, `out_valid` is 0 and `in_ready` is 1. Reset empties the spectrum history but does not touch the stored filter spectra.
- R2: For bin b of spectrum n, the output is `sat((sum over i=0..P-1 of X[n-i][b]*H[i][b]) >>> OSHIFT)`, with full complex products: real part `xr*hr - xi*hi` and imaginary part `xr*hi + xi*hr`.
- R3: History entries that do not exist yet contribute zero. This covers the time before `P` spectra have arrived since reset, even when stale data from before the reset is still stored.
- R4: A bin whose index is greater than `cutoff` produces an output of exactly zero on both parts. A bin whose index equals `cutoff` is processed normally. Out-of-band input bins are still stored in the history. `cutoff` is held stable within a spectrum.
- R5: `out_valid` rises on the `P`-th clock edge after the edge that accepts an in-band bin. For an out-of-band bin it rises on the accepting edge itself, so no multiply cycles are spent.
- R6: Only one bin is in flight at a time: `in_ready` is low from acceptance until the output handshake. While `out_valid` is high and `out_ready` is low, `out_re` and `out_im` hold their values.
- R7: A result beyond the signed `OW`-bit range clamps to `2^(OW-1)-1` or `-2^(OW-1)`, independently on each part.
- R8: A spectrum is `K+1` bins in index order 0..K. `out_last` is 1 exactly on the bin `K` output. The history advances by one slot after that output is taken.
- R9: A pulse on `h_wr` stores `(h_re, h_im)` as bin `h_bin` of partition `h_part`. Later outputs use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Filter spectrum write strobe |
| h_part | input | PW | Partition index of the write |
| h_bin | input | BW | Bin index of the write |
| h_re | input | CW | Filter bin real part, signed |
| h_im | input | CW | Filter bin imaginary part, signed |
| cutoff | input | BW | Highest bin index that is processed |
| in_valid | input | 1 | Input bin valid |
| in_ready | output | 1 | Core can accept an input bin |
| in_re | input | DW | Input bin real part, signed |
| in_im | input | DW | Input bin imaginary part, signed |
| out_valid | output | 1 | Output bin valid |
| out_ready | input | 1 | Downstream accepts the output bin |
| out_re | output | OW | Output bin real part, signed |
| out_im | output | OW | Output bin imaginary part, signed |
| out_last | output | 1 | Output bin is bin K of the spectrum |

## Verification
The bench builds the core with `P=3` and `K=4`. Because 3 is not a power of two, this exercises the compare-and-subtract history index variant rather than plain pointer wrap. With five bins per spectrum, the history wraps twice over six spectra. 12-bit inputs and coefficients with `OSHIFT=4` into a 16-bit output let full-scale bins drive both parts into positive and negative saturation. The cutoff is moved per spectrum: to bin 0, to an interior bin, and to the top bin. A mid-run reset then shows the history masking stale entries.

// File: rtl/fdl_pkg.sv
package fdl_pkg;
   typedef enum logic [1:0] {
      ST_TAKE = 2'd0,
      ST_MAC  = 2'd1,
      ST_SEND = 2'd2
   } fdl_state_e;
endpackage

// File: rtl/fdl_store.sv
module fdl_store #(
   parameter int P  = 8,
   parameter int K  = 64,
   parameter int DW = 16,
   parameter int CW = 16,
   parameter int PW = 3,
   parameter int BW = 7
) (
   input  logic                 clk,
   input  logic                 x_we,
   input  logic [PW-1:0]        x_slot,
   input  logic [BW-1:0]        x_bin,
   input  logic signed [DW-1:0] x_re,
   input  logic signed [DW-1:0] x_im,
   input  logic                 h_we,
   input  logic [PW-1:0]        h_part,
   input  logic [BW-1:0]        h_bin,
   input  logic signed [CW-1:0] h_re,
   input  logic signed [CW-1:0] h_im,
   input  logic [PW-1:0]        rd_slot,
   input  logic [PW-1:0]        rd_part,
   input  logic [BW-1:0]        rd_bin,
   output logic signed [DW-1:0] rd_xre,
   output logic signed [DW-1:0] rd_xim,
   output logic signed [CW-1:0] rd_hre,
   output logic signed [CW-1:0] rd_him
);
   localparam int NB = K + 1;

   logic signed [DW-1:0] xr [P][NB];
   logic signed [DW-1:0] xi [P][NB];
   logic signed [CW-1:0] hr [P][NB];
   logic signed [CW-1:0] hi [P][NB];

   logic h_ok;
   assign h_ok = h_we && (int'(h_part) < P) && (int'(h_bin) < NB);

   always_ff @(posedge clk) begin
      if (x_we) begin
         xr[x_slot][x_bin] <= x_re;
         xi[x_slot][x_bin] <= x_im;
      end
      if (h_ok) begin
         hr[h_part][h_bin] <= h_re;
         hi[h_part][h_bin] <= h_im;
      end
   end

   assign rd_xre = xr[rd_slot][rd_bin];
   assign rd_xim = xi[rd_slot][rd_bin];
   assign rd_hre = hr[rd_part][rd_bin];
   assign rd_him = hi[rd_part][rd_bin];
endmodule

// File: rtl/fdl_cmac.sv
module fdl_cmac #(
   parameter int DW = 16,
   parameter int CW = 16,
   parameter int AW = 36
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 en,
   input  logic                 keep,
   input  logic signed [DW-1:0] a_re,
   input  logic signed [DW-1:0] a_im,
   input  logic signed [CW-1:0] b_re,
   input  logic signed [CW-1:0] b_im,
   output logic signed [AW-1:0] acc_re,
   output logic signed [AW-1:0] acc_im
);
   localparam int MW = DW + CW;

   logic signed [MW-1:0] rr, ii, ri, ir;
   logic signed [AW-1:0] p_re, p_im;

   always_comb begin
      rr   = a_re * b_re;
      ii   = a_im * b_im;
      ri   = a_re * b_im;
      ir   = a_im * b_re;
      p_re = AW'(rr) - AW'(ii);
      p_im = AW'(ri) + AW'(ir);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         acc_re <= '0;
         acc_im <= '0;
      end else if (en && keep) begin
         acc_re <= acc_re + p_re;
         acc_im <= acc_im + p_im;
      end
   end

   // R3
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !keep && !clr) |=> ($stable(acc_re) && $stable(acc_im)));
endmodule

// File: rtl/fdl_accum.sv
module fdl_accum #(
   parameter int P      = 8,
   parameter int K      = 64,
   parameter int DW     = 16,
   parameter int CW     = 16,
   parameter int OW     = 16,
   parameter int OSHIFT = 15,
   localparam int PW    = $clog2(P),
   localparam int BW    = $clog2(K + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 h_wr,
   input  logic [PW-1:0]        h_part,
   input  logic [BW-1:0]        h_bin,
   input  logic signed [CW-1:0] h_re,
   input  logic signed [CW-1:0] h_im,
   input  logic [BW-1:0]        cutoff,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic signed [DW-1:0] in_re,
   input  logic signed [DW-1:0] in_im,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic signed [OW-1:0] out_re,
   output logic signed [OW-1:0] out_im,
   output logic                 out_last
);
   import fdl_pkg::*;

   localparam int AW = DW + CW + 1 + $clog2(P);
   localparam logic signed [AW-1:0] OMAX = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
   localparam logic signed [AW-1:0] OMIN = ~OMAX;
   localparam logic [PW-1:0] LASTP = PW'(P - 1);
   localparam logic [BW-1:0] LASTB = BW'(K);

   if (P < 2) begin : g_bad_p
      $error("fdl_accum: P must be at least 2");
   end
   if (K < 1) begin : g_bad_k
      $error("fdl_accum: K must be at least 1");
   end
   if (OW > AW || OSHIFT >= AW - 1) begin : g_bad_w
      $error("fdl_accum: OW or OSHIFT out of range");
   end

   fdl_state_e state;
   logic [PW-1:0] wptr, fill, idx, rd_slot;
   logic [BW-1:0] bin_cnt;
   logic accept, oob, take_out;
   logic signed [DW-1:0] rd_xre, rd_xim;
   logic signed [CW-1:0] rd_hre, rd_him;
   logic signed [AW-1:0] acc_re, acc_im;

   assign in_ready  = (state == ST_TAKE);
   assign out_valid = (state == ST_SEND);
   assign out_last  = out_valid && (bin_cnt == LASTB);
   assign accept    = in_valid && in_ready;
   assign take_out  = out_valid && out_ready;
   assign oob       = (bin_cnt > cutoff);

   // history slot of the entry idx spectra older than the newest
   if ((P & (P - 1)) == 0) begin : g_wrap_pow2
      assign rd_slot = wptr - idx;
   end else begin : g_wrap_gen
      assign rd_slot = (wptr >= idx) ? (wptr - idx) : (wptr + PW'(P) - idx);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_TAKE;
         wptr    <= '0;
         fill    <= '0;
         idx     <= '0;
         bin_cnt <= '0;
      end else begin
         unique case (state)
            ST_TAKE: if (accept) begin
               idx   <= '0;
               state <= oob ? ST_SEND : ST_MAC;
            end
            ST_MAC: begin
               idx <= idx + 1'b1;
               if (idx == LASTP) state <= ST_SEND;
            end
            ST_SEND: if (out_ready) begin
               state <= ST_TAKE;
               if (bin_cnt == LASTB) begin
                  bin_cnt <= '0;
                  wptr    <= (wptr == LASTP) ? '0 : wptr + 1'b1;
                  if (fill != LASTP) fill <= fill + 1'b1;
               end else begin
                  bin_cnt <= bin_cnt + 1'b1;
               end
            end
            default: state <= ST_TAKE;
         endcase
      end
   end

   fdl_store #(.P(P), .K(K), .DW(DW), .CW(CW), .PW(PW), .BW(BW)) u_store (
      .clk     (clk),
      .x_we    (accept),
      .x_slot  (wptr),
      .x_bin   (bin_cnt),
      .x_re    (in_re),
      .x_im    (in_im),
      .h_we    (h_wr),
      .h_part  (h_part),
      .h_bin   (h_bin),
      .h_re    (h_re),
      .h_im    (h_im),
      .rd_slot (rd_slot),
      .rd_part (idx),
      .rd_bin  (bin_cnt),
      .rd_xre  (rd_xre),
      .rd_xim  (rd_xim),
      .rd_hre  (rd_hre),
      .rd_him  (rd_him)
   );

   fdl_cmac #(.DW(DW), .CW(CW), .AW(AW)) u_cmac (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (accept),
      .en     (state == ST_MAC),
      .keep   (idx <= fill),
      .a_re   (rd_xre),
      .a_im   (rd_xim),
      .b_re   (rd_hre),
      .b_im   (rd_him),
      .acc_re (acc_re),
      .acc_im (acc_im)
   );

   function automatic logic signed [OW-1:0] clamp(input logic signed [AW-1:0] v);
      logic signed [AW-1:0] s;
      s = v >>> OSHIFT;
      if (s > OMAX)      return OMAX[OW-1:0];
      else if (s < OMIN) return OMIN[OW-1:0];
      else               return s[OW-1:0];
   endfunction

   assign out_re = clamp(acc_re);
   assign out_im = clamp(acc_im);

   // R1
   rst_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && in_ready));
   // R6
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)));
   // R4
   oob_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && oob) |-> (out_re == '0 && out_im == '0));
   // R8
   bin_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_out && out_last) |=> (bin_cnt == '0));
endmodule

// File: tb/sim_fdl_accum.sv
module sim_fdl_accum;
   localparam int TCLK = 10;
   localparam int P = 3, K = 4, DW = 12, CW = 12, OW = 16, OSHIFT = 4;
   localparam int PW = $clog2(P), BW = $clog2(K + 1);
   localparam int NS = 6;
   // per spectrum: re at bin 0, im at bin 0, re step, im step, cutoff
   localparam int TAB [NS][5] = '{
      '{  100,   -50,  30,  20, 4},
      '{ -200,    80, -15,  40, 2},
      '{   50,    50,  10, -10, 4},
      '{ 2000, -2000, -10,   5, 4},
      '{-2000,  1500,   0, -30, 0},
      '{    7,    -9,   3,   1, 4}
   };

   logic clk = 0, rst_n = 0;
   logic h_wr = 0;
   logic [PW-1:0] h_part = '0;
   logic [BW-1:0] h_bin = '0, cutoff = BW'(K);
   logic signed [CW-1:0] h_re = '0, h_im = '0;
   logic in_valid = 0, out_ready = 0;
   logic signed [DW-1:0] in_re = '0, in_im = '0;
   logic in_ready, out_valid, out_last;
   logic signed [OW-1:0] out_re, out_im;

   int checks = 0, errors = 0, cyc = 0;
   int mhr [P][K+1];
   int mhi [P][K+1];
   int mxr [NS+1][K+1];
   int mxi [NS+1][K+1];
   int mcut [NS+1];
   int start = 0;

   always #(TCLK/2) clk = ~clk;

   fdl_accum #(.P(P), .K(K), .DW(DW), .CW(CW), .OW(OW), .OSHIFT(OSHIFT)) u0 (
      .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_part(h_part), .h_bin(h_bin),
      .h_re(h_re), .h_im(h_im), .cutoff(cutoff), .in_valid(in_valid),
      .in_ready(in_ready), .in_re(in_re), .in_im(in_im), .out_valid(out_valid),
      .out_ready(out_ready), .out_re(out_re), .out_im(out_im), .out_last(out_last)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic load_h(input int p, input int b, input int re, input int im);
      @(negedge clk);
      h_wr = 1; h_part = PW'(p); h_bin = BW'(b); h_re = CW'(re); h_im = CW'(im);
      @(posedge clk); #1 h_wr = 0;
      mhr[p][b] = re; mhi[p][b] = im;
   endtask

   function automatic longint model(input int s, input int b, input bit want_im);
      longint acc = 0;
      if (b > mcut[s]) return 0;
      for (int i = 0; i < P; i++) begin
         if (s - i >= start) begin
            if (want_im) acc += longint'(mxr[s-i][b]) * mhi[i][b] + longint'(mxi[s-i][b]) * mhr[i][b];
            else         acc += longint'(mxr[s-i][b]) * mhr[i][b] - longint'(mxi[s-i][b]) * mhi[i][b];
         end
      end
      acc = acc >>> OSHIFT;
      if (acc > 32767) acc = 32767;
      if (acc < -32768) acc = -32768;
      return acc;
   endfunction

   task automatic run_bin(input int s, input int b);
      int n;
      longint er, ei;
      @(negedge clk);
      chk(in_ready == 1'b1, "R6 in_ready idle", in_ready, 1);
      in_valid = 1; in_re = DW'(mxr[s][b]); in_im = DW'(mxi[s][b]);
      @(posedge clk); #1 in_valid = 0;
      @(negedge clk);
      n = 0;
      if (b <= mcut[s]) chk(in_ready == 1'b0, "R6 busy", in_ready, 0);
      while (!out_valid && n < 50) begin
         @(negedge clk); n++;
      end
      // R5 latency in edges after acceptance
      chk(n == ((b > mcut[s]) ? 0 : P), "R5 latency", n, (b > mcut[s]) ? 0 : P);
      er = model(s, b, 0); ei = model(s, b, 1);
      // R2 R3 R4 R7 value
      chk(longint'(out_re) == er, (b > mcut[s]) ? "R4 re" : "R2 re", out_re, er);
      chk(longint'(out_im) == ei, (b > mcut[s]) ? "R4 im" : "R2 im", out_im, ei);
      chk(out_last == (b == K), "R8 last", out_last, (b == K));
      if (b == 2) begin
         for (int w = 0; w < 2; w++) begin
            @(negedge clk);
            chk(out_valid && longint'(out_re) == er && longint'(out_im) == ei,
                "R6 hold", out_re, er);
         end
      end
      out_ready = 1;
      @(posedge clk); #1 out_ready = 0;
   endtask

   task automatic run_spec(input int s, input int row);
      mcut[s] = TAB[row][4];
      for (int b = 0; b <= K; b++) begin
         mxr[s][b] = TAB[row][0] + b * TAB[row][2];
         mxi[s][b] = TAB[row][1] + b * TAB[row][3];
      end
      @(negedge clk); cutoff = BW'(mcut[s]);
      for (int b = 0; b <= K; b++) run_bin(s, b);
   endtask

   initial begin
      forever begin
         @(posedge clk); cyc++;
         if (cyc > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 during reset
      chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 reset", out_valid, 0);
      // R9 filter load through the write port
      for (int p = 0; p < P; p++)
         for (int b = 0; b <= K; b++)
            load_h(p, b, (p == 0 && b == 0) ? 2000 : 100 * (p + 1) + 10 * b - 60,
                   20 * b - 50 * p + 5);
      @(negedge clk); rst_n = 1;
      @(negedge clk);
      chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 after reset", in_ready, 1);
      for (int s = 0; s < NS; s++) begin
         // R9 coefficient rewrite mid-run
         if (s == 3) load_h(2, 2, -500, 300);
         run_spec(s, s);
      end
      // R1 R3 mid-run reset: stale history must not contribute
      @(negedge clk); rst_n = 0;
      @(posedge clk); #1;
      chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 mid reset", out_valid, 0);
      @(negedge clk); rst_n = 1;
      start = NS;
      run_spec(NS, 0);
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule